// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers bytes from an idle-high asynchronous serial line. Each frame carries ten bit periods: a low start bit, eight data bits sent least significant bit first, and a high stop bit. A one-cycle enable, `tick_i`, pulses at sixteen times the bit rate. On each tick the line is examined once. The line is first passed through a two-stage synchronizer.

While the receiver waits, only a high-to-low change on the synchronized line starts a frame. That change clears the sub-bit counter on the spot, so later count values fall at fixed offsets from the start of each bit. Each bit is settled by a two-of-three vote over the samples taken at counts 7, 8 and 9. The nine-bit shift register is loaded with ones when the frame begins. When the start bit's zero reaches its low end, all eight data bits are present. The next vote settles the stop bit. At that point the byte and the stop bit are latched and a done flag is raised. The done flag stays high until the `done_clr_i` input drops it.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_byte_o` is 0x00, `rx_stop_o` is 0 and `rx_done_o` is 0.
- R2: A line that stays high starts no frame. `rx_done_o` and `rx_byte_o` keep their values.
- R3: A frame begins on the first tick where the synchronized line is low and was high on the previous tick. The sub-bit count restarts at that tick, so frames are decoded whatever their phase against `tick_i`, including frames sent back to back.
- R4: The eight data bits are assembled least significant bit first. `rx_byte_o` changes only in a cycle where `rx_done_o` is high afterwards.
- R5: Each bit takes the majority value of the samples at counts 7, 8 and 9. A single-tick inverted glitch inside a bit does not alter the decoded byte.
- R6: If the start bit votes high, the frame is abandoned. No done is raised, the outputs are unchanged, and the next genuine frame is decoded correctly.
- R7: The voted stop bit appears on `rx_stop_o` (1 = proper stop, 0 = framing error). A zero stop still completes the frame and raises done.
- R8: `rx_done_o` rises one clock after the tick that votes the stop bit. It then stays high while `done_clr_i` is low.
- R9: `done_clr_i` high at a clock edge clears `rx_done_o`, unless a frame completes at that same edge. In that case the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| done_clr_i | input | 1 | Clears the done flag |
| rx_byte_o | output | 8 | Last received byte |
| rx_stop_o | output | 1 | Stop bit of the last frame |
| rx_done_o | output | 1 | Frame-complete flag |

## Verification
The done flag can be set by a completing frame in the very clock where software-style clearing is requested. The bench provokes this by holding `done_clr_i` high for a whole frame. The flag must show high for exactly the completion cycle and be low afterwards. The received byte must still be correct. Every clock is also compared against a behavioural model that votes samples and counts bits with integers. This covers glitches, false starts and phase offsets of the line against the tick.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_STOP = 2'd2
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic din_i,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[STAGES-2:0], din_i};
        if (tick_i) begin
            sync_d.prev = sync_q.pipe[STAGES-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '{pipe: '1, prev: 1'b1};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.pipe[STAGES-1];
    assign fall_o  = tick_i & sync_q.prev & ~sync_q.pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote import uart_rx_pkg::*; #(
    parameter int OSR = 16,
    localparam int CW  = $clog2(OSR),
    localparam int MID = OSR / 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          din_i,
    output logic          decide_o,
    output logic          bit_o
);
    typedef struct packed {
        logic early;
        logic centre;
    } vote_t;

    vote_t vote_d, vote_q;

    always_comb begin
        vote_d = vote_q;
        if (en_i && cnt_i == CW'(MID - 1)) vote_d.early  = din_i;
        if (en_i && cnt_i == CW'(MID))     vote_d.centre = din_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vote_q <= '{early: 1'b1, centre: 1'b1};
        end else begin
            vote_q <= vote_d;
        end
    end

    assign decide_o = en_i && (cnt_i == CW'(MID + 1));
    assign bit_o    = maj3(vote_q.early, vote_q.centre, din_i);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_rx_pkg::*; #(
    parameter int OSR = 16,
    parameter int DW  = 8,
    localparam int CW = $clog2(OSR),
    localparam int SW = DW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          fall_i,
    input  logic          dec_i,
    input  logic          dec_bit_i,
    input  logic          done_clr_i,
    output logic [CW-1:0] cnt_nxt_o,
    output logic          sample_en_o,
    output logic          done_set_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          rx_stop_o,
    output logic          rx_done_o
);
    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [SW-1:0] sh;
        logic [DW-1:0] data;
        logic          stop;
        logic          done;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   set;

    assign cnt_nxt_o   = (fr_q.cnt == CW'(OSR - 1)) ? '0 : fr_q.cnt + CW'(1);
    assign sample_en_o = tick_i && (fr_q.st != RX_IDLE);

    always_comb begin
        fr_d = fr_q;
        set  = 1'b0;
        if (tick_i) begin
            unique case (fr_q.st)
                RX_IDLE: begin
                    if (fall_i) begin
                        fr_d.st  = RX_DATA;
                        fr_d.cnt = '0;
                        fr_d.sh  = '1;
                    end
                end
                RX_DATA: begin
                    fr_d.cnt = cnt_nxt_o;
                    if (dec_i) begin
                        if ((&fr_q.sh) && dec_bit_i) begin
                            fr_d.st = RX_IDLE;
                        end else begin
                            fr_d.sh = {dec_bit_i, fr_q.sh[SW-1:1]};
                            if (!fr_d.sh[0]) fr_d.st = RX_STOP;
                        end
                    end
                end
                RX_STOP: begin
                    fr_d.cnt = cnt_nxt_o;
                    if (dec_i) begin
                        fr_d.data = fr_q.sh[SW-1:1];
                        fr_d.stop = dec_bit_i;
                        fr_d.st   = RX_IDLE;
                        set       = 1'b1;
                    end
                end
                default: fr_d.st = RX_IDLE;
            endcase
        end
        if (done_clr_i) fr_d.done = 1'b0;
        if (set)        fr_d.done = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fr_q <= '{st: RX_IDLE, cnt: '0, sh: '1, data: '0, stop: 1'b0, done: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done_set_o = set;
    assign rx_byte_o  = fr_q.data;
    assign rx_stop_o  = fr_q.stop;
    assign rx_done_o  = fr_q.done;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
    parameter int OSR       = 16,
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2,
    localparam int CW = $clog2(OSR)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          rxd_i,
    input  logic          done_clr_i,
    output logic [DW-1:0] rx_byte_o,
    output logic          rx_stop_o,
    output logic          rx_done_o
);
    logic          line_lvl;
    logic          line_fall;
    logic [CW-1:0] cnt_nxt;
    logic          sample_en;
    logic          bit_dec;
    logic          bit_val;
    logic          done_set;

    uart_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .din_i   (rxd_i),
        .level_o (line_lvl),
        .fall_o  (line_fall)
    );

    uart_rx_vote #(.OSR(OSR)) u_vote (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (sample_en),
        .cnt_i    (cnt_nxt),
        .din_i    (line_lvl),
        .decide_o (bit_dec),
        .bit_o    (bit_val)
    );

    uart_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .fall_i      (line_fall),
        .dec_i       (bit_dec),
        .dec_bit_i   (bit_val),
        .done_clr_i  (done_clr_i),
        .cnt_nxt_o   (cnt_nxt),
        .sample_en_o (sample_en),
        .done_set_o  (done_set),
        .rx_byte_o   (rx_byte_o),
        .rx_stop_o   (rx_stop_o),
        .rx_done_o   (rx_done_o)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tick_i,
    input logic          done_clr_i,
    input logic          done_set,
    input logic [DW-1:0] rx_byte_o,
    input logic          rx_stop_o,
    input logic          rx_done_o
);
    AST_BYTE_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rx_byte_o) |-> rx_done_o); // R4
    AST_STOP_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rx_stop_o) |-> rx_done_o); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_done_o && !done_clr_i) |=> rx_done_o); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_clr_i && !done_set) |=> !rx_done_o); // R9
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_set |=> rx_done_o); // R9
    AST_SET_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_set |-> tick_i); // R3
endmodule

bind uart_os_rx uart_os_rx_chk #(.DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .done_clr_i (done_clr_i),
    .done_set   (done_set),
    .rx_byte_o  (rx_byte_o),
    .rx_stop_o  (rx_stop_o),
    .rx_done_o  (rx_done_o)
);

// File: tb/test_uart_os_rx.sv
`timescale 1ns/1ps
module test_uart_os_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       clr = 1'b0;
    logic [7:0] byte_o;
    logic       stop_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    always #4 clk = ~clk;

    uart_os_rx i_uart_os_rx (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .rxd_i      (rxd),
        .done_clr_i (clr),
        .rx_byte_o  (byte_o),
        .rx_stop_o  (stop_o),
        .rx_done_o  (done_o)
    );

    // tick every third clock
    always @(negedge clk) begin
        tcnt = (tcnt == 2) ? 0 : tcnt + 1;
        tick = (tcnt == 2);
    end

    // behavioural reference model
    int m_s1, m_s2, m_prev, m_busy, m_cnt, m_bit, m_a, m_b;
    logic [7:0] m_acc, m_byte;
    logic m_stop, m_done;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_busy = 0; m_cnt = 0; m_bit = 0;
            m_a = 1; m_b = 1; m_acc = 0; m_byte = 0; m_stop = 0; m_done = 0;
        end else begin
            automatic bit fin = 0;
            if (tick) begin
                if (m_busy == 0) begin
                    if (m_prev == 1 && m_s2 == 0) begin
                        m_busy = 1; m_cnt = 0; m_bit = 0;
                    end
                end else begin
                    m_cnt = (m_cnt + 1) % 16;
                    if (m_cnt == 7) m_a = m_s2;
                    if (m_cnt == 8) m_b = m_s2;
                    if (m_cnt == 9) begin
                        automatic bit v = (m_a + m_b + m_s2) >= 2;
                        if (m_bit == 0) begin
                            if (v) m_busy = 0; else m_bit = 1;
                        end else if (m_bit <= 8) begin
                            m_acc[m_bit-1] = v;
                            m_bit++;
                        end else begin
                            m_byte = m_acc; m_stop = v; fin = 1; m_busy = 0;
                        end
                    end
                end
                m_prev = m_s2;
            end
            if (clr) m_done = 0;
            if (fin) m_done = 1;
            m_s2 = m_s1;
            m_s1 = int'(rxd);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model (R3 frame timing)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(byte_o == m_byte, "R3 model byte", byte_o, m_byte);
            chk(stop_o == m_stop, "R3 model stop", stop_o, m_stop);
            chk(done_o == m_done, "R3 model done", done_o, m_done);
        end
    end

    task automatic send_frame(input logic [7:0] b, input logic stopv, input int glitch);
        for (int i = 0; i < 10; i++) begin
            automatic logic v = (i == 0) ? 1'b0 : (i == 9) ? stopv : b[i-1];
            rxd = v;
            if (i == glitch) begin
                repeat (24) @(negedge clk);
                rxd = ~v;
                repeat (3) @(negedge clk);
                rxd = v;
                repeat (21) @(negedge clk);
            end else begin
                repeat (48) @(negedge clk);
            end
        end
        rxd = 1'b1;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(done_o == 1'b0, "R9 clear", done_o, 0);
    endtask

    task automatic expect_frame(input logic [7:0] b, input logic s, input string tag);
        chk(byte_o == b, tag, byte_o, b);
        chk(stop_o == s, "R7 stop bit", stop_o, s);
        chk(done_o == 1'b1, "R8 done set", done_o, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit saw;
        repeat (5) @(negedge clk);
        chk(byte_o == 8'h00, "R1 reset byte", byte_o, 0);
        chk(stop_o == 1'b0, "R1 reset stop", stop_o, 0);
        chk(done_o == 1'b0, "R1 reset done", done_o, 0);
        rst_n = 1'b1;

        repeat (200) @(negedge clk);
        chk(done_o == 1'b0, "R2 idle no done", done_o, 0);
        chk(byte_o == 8'h00, "R2 idle byte", byte_o, 0);

        send_frame(8'hA5, 1'b1, -1);
        expect_frame(8'hA5, 1'b1, "R4 byte A5");
        repeat (60) @(negedge clk);
        chk(done_o == 1'b1, "R8 done holds", done_o, 1);
        pulse_clr();

        send_frame(8'h00, 1'b1, -1);
        expect_frame(8'h00, 1'b1, "R4 byte 00");
        pulse_clr();
        send_frame(8'hFF, 1'b1, -1);
        expect_frame(8'hFF, 1'b1, "R4 byte FF");
        pulse_clr();

        send_frame(8'h3C, 1'b1, 4);
        expect_frame(8'h3C, 1'b1, "R5 glitch in data");
        pulse_clr();
        send_frame(8'h96, 1'b1, 0);
        expect_frame(8'h96, 1'b1, "R5 glitch in start");
        pulse_clr();

        // false start: low for three ticks only
        rxd = 1'b0;
        repeat (9) @(negedge clk);
        rxd = 1'b1;
        repeat (600) @(negedge clk);
        chk(done_o == 1'b0, "R6 false start no done", done_o, 0);
        chk(byte_o == 8'h96, "R6 false start byte kept", byte_o, 8'h96);
        send_frame(8'h81, 1'b1, -1);
        expect_frame(8'h81, 1'b1, "R6 recovery byte");
        pulse_clr();

        send_frame(8'h5A, 1'b0, -1);
        expect_frame(8'h5A, 1'b0, "R7 framing error byte");
        repeat (40) @(negedge clk);
        pulse_clr();

        // phase offsets and back-to-back frames
        repeat (1) @(negedge clk);
        send_frame(8'hC3, 1'b1, -1);
        expect_frame(8'hC3, 1'b1, "R3 phase 1");
        pulse_clr();
        repeat (2) @(negedge clk);
        send_frame(8'h12, 1'b1, -1);
        send_frame(8'hE7, 1'b1, -1);
        expect_frame(8'hE7, 1'b1, "R3 back to back");
        pulse_clr();

        // clear held through a whole frame: set must win once
        saw = 1'b0;
        clr = 1'b1;
        fork
            send_frame(8'h77, 1'b1, -1);
            begin
                repeat (480) begin
                    @(negedge clk);
                    if (done_o) saw = 1'b1;
                end
            end
        join
        repeat (2) @(negedge clk);
        clr = 1'b0;
        chk(saw == 1'b1, "R9 set wins over clear", saw, 1);
        chk(done_o == 1'b0, "R9 cleared afterwards", done_o, 0);
        chk(byte_o == 8'h77, "R9 byte during clear", byte_o, 8'h77);

        repeat (20) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule